// File: doc/BRIEF.md
# Flash Write-Qualification and Security-Lock Controller

This block is the command front end of a NOR-style flash model. A bus write comes in on three active-low strobes (chip enable, write enable, output enable) with an address and a data byte. The strobes are sampled on the system clock. A write is turned into a single-cycle accepted-write strobe only when three tests all pass. The strobe combination must be a legal write. It must last long enough not to be a glitch. The supply must not be flagged as below the lockout level.

The accepted writes drive a small command sequencer. The sequencer recognises unlock-prefixed commands: program a location, enter the security region, leave it, and permanently lock the security sector. The block reports whether accesses currently target the security region and whether that sector is locked. It also issues a program-start pulse with the target address and data only after a full, correct sequence. The lock can be set once and is cleared only by the power-on initialisation input. The hardware reset and the low-supply flag both return the controller to read-array mode but leave the lock in place.

Top module: `flash_write_qual`

## Requirements
- R1: A strobe sample counts as an active write only when `ce_n`=0, `we_n`=0 and `oe_n`=1 at the same time. With `oe_n`=0 or `ce_n`=1, no `wr_accept` pulse is produced, however long the strobes are held.
- R2: An active write must last at least `MIN_PULSE` consecutive clock samples to be accepted. The default is 5, derived from a 5000 ps limit at a 1000 ps clock. A shorter run produces nothing. A valid run produces exactly one single-cycle `wr_accept` pulse after the strobes are released, however long it lasted.
- R3: While `vlow`=1 no write is accepted and the mode and sequencer are held in reset. A write whose strobes are active only while `vlow`=1 is lost, and a command interrupted by `vlow` starts nothing.
- R4: After `rst_n`=0 or `por_n`=0 (synchronous, active low), `sec_mode`=0 (read array), and `wr_accept` and `prog_go` are 0.
- R5: Commands compare only address bits [10:0]. A program starts only after all of these, in order: AAh at 555h, 55h at 2AAh, A0h at 555h, then one more write. That write raises `prog_go` for one cycle, with `prog_addr`/`prog_data` equal to that write's address and data. Any mismatch returns the sequencer to idle, and a partial sequence raises no `prog_go`.
- R6: The sequence AAh at 555h, 55h at 2AAh, 88h at 555h sets `sec_mode`=1. While the sector is unlocked, a program in that mode raises `prog_go` with `prog_sec`=1.
- R7: In security mode, 90h at 555h followed by a write of 00h sets `sec_mode`=0. A hardware reset does the same.
- R8: In security mode, AAh at 555h, 55h at 2AAh, 60h at 555h sets `sec_locked`=1. The lock stays set through `rst_n`, `vlow` and the exit command, and only `por_n`=0 clears it.
- R9: With `sec_locked`=1, a program issued in security mode raises no `prog_go`. A program issued in read-array mode still raises `prog_go` with `prog_sec`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Hardware reset, synchronous, active low |
| por_n | input | 1 | Power-on initialisation, synchronous, active low; also clears the lock |
| vlow | input | 1 | Supply below lockout level |
| ce_n | input | 1 | Chip enable strobe, active low |
| we_n | input | 1 | Write enable strobe, active low |
| oe_n | input | 1 | Output enable strobe, active low |
| addr | input | ADDR_W | Bus address |
| wdata | input | DATA_W | Bus write data |
| wr_accept | output | 1 | One-cycle pulse per qualified write |
| sec_mode | output | 1 | 1 = security region, 0 = read array |
| sec_locked | output | 1 | Security sector lock status |
| prog_go | output | 1 | One-cycle program-start pulse |
| prog_sec | output | 1 | Region of the program at `prog_go` |
| prog_addr | output | ADDR_W | Program target address |
| prog_data | output | DATA_W | Program data |

## Verification
The hardest state to reach from the ports is a locked sector seen from every path that could disturb it. The bench must first build a full unlock, enter and protect series out of filtered, width-qualified strobe pulses. It then sends a hardware reset, a low-supply interval and the exit command against the lock, and tries a security-region program after each. Each write is issued by one task with an explicit pulse width. This task also produces the 4-versus-5-sample glitch boundary and the command interrupted by the low-supply flag.

// File: rtl/fwq_pkg.sv
// Package fwq_pkg
// Shared sequencer state type and command byte values for the flash
// write-qualification controller. Assumes 8-bit command data.
package fwq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_UNLK1,
        S_UNLK2,
        S_PROG,
        S_EXIT
    } seq_state_t;

    localparam logic [7:0]  CMD_UNLK_A  = 8'hAA;
    localparam logic [7:0]  CMD_UNLK_B  = 8'h55;
    localparam logic [7:0]  CMD_PROG    = 8'hA0;
    localparam logic [7:0]  CMD_SEC_IN  = 8'h88;
    localparam logic [7:0]  CMD_SEC_OUT = 8'h90;
    localparam logic [7:0]  CMD_LOCK    = 8'h60;
    localparam logic [7:0]  CMD_ZERO    = 8'h00;
    localparam logic [10:0] ADR_A       = 11'h555;
    localparam logic [10:0] ADR_B       = 11'h2AA;

endpackage

// File: rtl/fwq_strobe_filter.sv
// Module fwq_strobe_filter
// Samples the asynchronous bus strobes once per clock. It checks the
// logical write combination and counts how long it stays valid. When the
// strobes are released after at least MIN_PULSE valid samples, it emits a
// one-cycle accept pulse with the last sampled address and data.
// Assumes address and data are stable while the strobes are active.
module fwq_strobe_filter #(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int MIN_PULSE = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              acc,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [DATA_W-1:0] acc_data
);

    localparam int CW = $clog2(MIN_PULSE + 1);
    localparam logic [CW-1:0] CMAX = CW'(MIN_PULSE);

    logic              act_s;
    logic [ADDR_W-1:0] addr_s;
    logic [DATA_W-1:0] data_s;
    logic [CW-1:0]     cnt;

    // Sample strobes, count the valid run, fire on release of a long run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_s    <= 1'b0;
            addr_s   <= '0;
            data_s   <= '0;
            cnt      <= '0;
            acc      <= 1'b0;
            acc_addr <= '0;
            acc_data <= '0;
        end else begin
            act_s  <= !ce_n && !we_n && oe_n;
            addr_s <= addr;
            data_s <= wdata;
            if (act_s) begin
                cnt      <= (cnt == CMAX) ? cnt : cnt + 1'b1;
                acc_addr <= addr_s;
                acc_data <= data_s;
                acc      <= 1'b0;
            end else begin
                acc <= (cnt == CMAX);
                cnt <= '0;
            end
        end
    end

    // R2: an accept is a single-cycle pulse
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> !acc);

    // R2: an accept only follows the end of a sampled valid run
    a_r2_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        acc |-> $past(!act_s));

endmodule

// File: rtl/fwq_cmd_seq.sv
// Module fwq_cmd_seq
// Command sequencer fed by qualified writes. It decodes the unlock
// prefix and then the program, security-enter, security-lock and exit
// commands. Only address bits [10:0] are compared. Assumes DATA_W >= 8
// and ADDR_W >= 11.
module fwq_cmd_seq
    import fwq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_data,
    input  logic              locked,
    output logic              sec_mode,
    output logic              set_lock,
    output logic              prog_go,
    output logic              prog_sec,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [DATA_W-1:0] prog_data
);

    seq_state_t state;
    logic       at_a, at_b;
    logic [7:0] cmd;

    // Decode helpers for the two command addresses and the command byte.
    always_comb begin
        at_a = (acc_addr[10:0] == ADR_A);
        at_b = (acc_addr[10:0] == ADR_B);
        cmd  = acc_data[7:0];
    end

    // Advance the sequence on each accepted write; any mismatch goes idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            sec_mode  <= 1'b0;
            set_lock  <= 1'b0;
            prog_go   <= 1'b0;
            prog_sec  <= 1'b0;
            prog_addr <= '0;
            prog_data <= '0;
        end else begin
            set_lock <= 1'b0;
            prog_go  <= 1'b0;
            if (acc) begin
                state <= S_IDLE;
                unique case (state)
                    S_IDLE: begin
                        if (at_a && cmd == CMD_UNLK_A)
                            state <= S_UNLK1;
                        else if (sec_mode && at_a && cmd == CMD_SEC_OUT)
                            state <= S_EXIT;
                    end
                    S_UNLK1: begin
                        if (at_b && cmd == CMD_UNLK_B)
                            state <= S_UNLK2;
                    end
                    S_UNLK2: begin
                        if (at_a && cmd == CMD_PROG)
                            state <= S_PROG;
                        else if (at_a && cmd == CMD_SEC_IN)
                            sec_mode <= 1'b1;
                        else if (sec_mode && at_a && cmd == CMD_LOCK)
                            set_lock <= 1'b1;
                    end
                    S_PROG: begin
                        if (!(sec_mode && locked)) begin
                            prog_go   <= 1'b1;
                            prog_sec  <= sec_mode;
                            prog_addr <= acc_addr;
                            prog_data <= acc_data;
                        end
                    end
                    S_EXIT: begin
                        if (cmd == CMD_ZERO)
                            sec_mode <= 1'b0;
                    end
                    default: state <= S_IDLE;
                endcase
            end
        end
    end

    // R6: security mode is entered only from the end of the unlock prefix
    a_r6_enter_after_unlock: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sec_mode) |-> $past(state) == S_UNLK2);

    // R5: a program start only follows the program-setup state
    a_r5_prog_after_setup: assert property (@(posedge clk) disable iff (!rst_n)
        prog_go |-> $past(state) == S_PROG);

    // R7: leaving security mode only follows the exit prefix
    a_r7_exit_after_prefix: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sec_mode) |-> $past(state) == S_EXIT);

endmodule

// File: rtl/fwq_lock_reg.sv
// Module fwq_lock_reg
// One-way lock bit for the security sector. It is set by a pulse from
// the sequencer and cleared only by the power-on initialisation input.
// It ignores the hardware reset and the low-supply flag by design.
module fwq_lock_reg (
    input  logic clk,
    input  logic por_n,
    input  logic set,
    output logic locked
);

    // Hold the lock; only power-on initialisation clears it.
    always_ff @(posedge clk) begin
        if (!por_n)
            locked <= 1'b0;
        else if (set)
            locked <= 1'b1;
    end

    // R8: once set, the lock stays set until power-on initialisation
    a_r8_lock_sticky: assert property (@(posedge clk) disable iff (!por_n)
        locked |=> locked);

endmodule

// File: rtl/flash_write_qual.sv
// Module flash_write_qual
// Top of the flash write-qualification and security-lock controller. It
// combines the hardware reset, the power-on initialisation and the
// low-supply flag into one synchronous reset for the filter and
// sequencer. The lock register sees only power-on initialisation.
// Assumes CLK_PERIOD_PS is the period of clk.
module flash_write_qual #(
    parameter int ADDR_W        = 16,
    parameter int DATA_W        = 8,
    parameter int CLK_PERIOD_PS = 1000,
    parameter int GLITCH_PS     = 5000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic              vlow,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              wr_accept,
    output logic              sec_mode,
    output logic              sec_locked,
    output logic              prog_go,
    output logic              prog_sec,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [DATA_W-1:0] prog_data
);

    localparam int MIN_PULSE = (GLITCH_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;

    logic              core_rst_n;
    logic [ADDR_W-1:0] acc_addr;
    logic [DATA_W-1:0] acc_data;
    logic              set_lock;

    // Merge all reset sources that return the controller to read array.
    always_comb core_rst_n = rst_n && por_n && !vlow;

    fwq_strobe_filter #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MIN_PULSE(MIN_PULSE)
    ) u_filter (
        .clk(clk), .rst_n(core_rst_n),
        .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .wdata(wdata),
        .acc(wr_accept), .acc_addr(acc_addr), .acc_data(acc_data)
    );

    fwq_cmd_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_seq (
        .clk(clk), .rst_n(core_rst_n),
        .acc(wr_accept), .acc_addr(acc_addr), .acc_data(acc_data),
        .locked(sec_locked), .sec_mode(sec_mode), .set_lock(set_lock),
        .prog_go(prog_go), .prog_sec(prog_sec),
        .prog_addr(prog_addr), .prog_data(prog_data)
    );

    fwq_lock_reg u_lock (
        .clk(clk), .por_n(por_n), .set(set_lock), .locked(sec_locked)
    );

    // R3: a low-supply cycle leaves no accept behind it
    a_r3_vlow_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        vlow |=> !wr_accept);

    // R9: a locked sector never receives a program start
    a_r9_locked_no_sec_prog: assert property (@(posedge clk) disable iff (!rst_n)
        prog_go |-> !(prog_sec && sec_locked));

    // R4: a hardware reset leaves read-array mode behind it
    a_r4_reset_read: assert property (@(posedge clk)
        !rst_n |=> !sec_mode && !prog_go);

endmodule

// File: tb/tb_flash_write_qual.sv
// Directed bench for flash_write_qual: one task per scenario.
module tb_flash_write_qual;

    localparam int AW = 16;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0, por_n = 1'b0, vlow = 1'b0;
    logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          wr_accept, sec_mode, sec_locked, prog_go, prog_sec;
    logic [AW-1:0] prog_addr;
    logic [DW-1:0] prog_data;

    int n_chk = 0, n_bad = 0;
    int acc_cnt = 0, prog_cnt = 0;
    logic [AW-1:0] last_paddr;
    logic [DW-1:0] last_pdata;
    logic          last_psec;

    flash_write_qual dut (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .vlow(vlow),
        .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .addr(addr), .wdata(wdata),
        .wr_accept(wr_accept), .sec_mode(sec_mode), .sec_locked(sec_locked),
        .prog_go(prog_go), .prog_sec(prog_sec),
        .prog_addr(prog_addr), .prog_data(prog_data)
    );

    always #5 clk = ~clk;

    // Count output pulses away from the active edge.
    always @(negedge clk) begin
        if (wr_accept) acc_cnt++;
        if (prog_go) begin
            prog_cnt++;
            last_paddr = prog_addr;
            last_pdata = prog_data;
            last_psec  = prog_sec;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One bus cycle with explicit strobe levels and active width.
    task automatic bus(input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input int width, input logic ce = 1'b0,
                       input logic oe = 1'b1);
        @(negedge clk);
        addr = a; wdata = d; ce_n = ce; oe_n = oe; we_n = 1'b0;
        repeat (width) @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        bus(a, d, 6);
    endtask

    task automatic unlock();
        wr(16'h0555, 8'hAA);
        wr(16'h02AA, 8'h55);
    endtask

    task automatic hw_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic power_on();
        @(negedge clk); por_n = 1'b0; rst_n = 1'b0;
        repeat (3) @(negedge clk); por_n = 1'b1; rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        power_on();
        chk("R4 sec_mode after power-on", sec_mode, 0);
        chk("R4 lock after power-on", sec_locked, 0);
        chk("R4 no accept after power-on", acc_cnt, 0);
    endtask

    task automatic t_logic_inhibit();
        int a0 = acc_cnt;
        bus(16'h0100, 8'h11, 8, 1'b0, 1'b0);
        chk("R1 oe_n low blocks write", acc_cnt - a0, 0);
        bus(16'h0100, 8'h11, 8, 1'b1, 1'b1);
        chk("R1 ce_n high blocks write", acc_cnt - a0, 0);
        bus(16'h0100, 8'h11, 8);
        chk("R1 valid combination accepted", acc_cnt - a0, 1);
    endtask

    task automatic t_glitch();
        int a0 = acc_cnt;
        bus(16'h0100, 8'h22, 4);
        chk("R2 4-sample pulse rejected", acc_cnt - a0, 0);
        bus(16'h0100, 8'h22, 5);
        chk("R2 5-sample pulse accepted", acc_cnt - a0, 1);
        bus(16'h0100, 8'h22, 20);
        chk("R2 long pulse accepted once", acc_cnt - a0, 2);
    endtask

    task automatic t_program();
        int p0 = prog_cnt;
        unlock();
        wr(16'h0555, 8'hA0);
        wr(16'h1234, 8'h5A);
        chk("R5 program starts once", prog_cnt - p0, 1);
        chk("R5 program address", last_paddr, 16'h1234);
        chk("R5 program data", last_pdata, 8'h5A);
        chk("R5 array region", last_psec, 0);
        unlock();
        wr(16'h0555, 8'h12);
        wr(16'h1234, 8'h5A);
        chk("R5 wrong third byte starts nothing", prog_cnt - p0, 1);
        wr(16'h0555, 8'hAA);
        wr(16'h02AB, 8'h55);
        wr(16'h0555, 8'hA0);
        wr(16'h1234, 8'h5A);
        chk("R5 wrong unlock address starts nothing", prog_cnt - p0, 1);
    endtask

    task automatic t_vlow();
        int a0 = acc_cnt;
        int p0 = prog_cnt;
        @(negedge clk); vlow = 1'b1;
        bus(16'h0100, 8'h33, 8);
        @(negedge clk); vlow = 1'b0;
        @(negedge clk);
        chk("R3 write under low supply lost", acc_cnt - a0, 0);
        unlock();
        @(negedge clk); vlow = 1'b1;
        @(negedge clk); vlow = 1'b0;
        wr(16'h0555, 8'hA0);
        wr(16'h2000, 8'h44);
        chk("R3 interrupted command starts nothing", prog_cnt - p0, 0);
    endtask

    task automatic t_security();
        int p0 = prog_cnt;
        unlock();
        wr(16'h0555, 8'h88);
        chk("R6 security mode entered", sec_mode, 1);
        unlock();
        wr(16'h0555, 8'hA0);
        wr(16'h0010, 8'hC3);
        chk("R6 unlocked security program starts", prog_cnt - p0, 1);
        chk("R6 program in security region", last_psec, 1);
        wr(16'h0555, 8'h90);
        wr(16'h0000, 8'h00);
        chk("R7 exit command returns to read array", sec_mode, 0);
        unlock();
        wr(16'h0555, 8'h88);
        hw_reset();
        chk("R7 hardware reset returns to read array", sec_mode, 0);
    endtask

    task automatic t_lock();
        int p0;
        unlock();
        wr(16'h0555, 8'h88);
        unlock();
        wr(16'h0555, 8'h60);
        chk("R8 lock set", sec_locked, 1);
        p0 = prog_cnt;
        unlock();
        wr(16'h0555, 8'hA0);
        wr(16'h0010, 8'hEE);
        chk("R9 locked security program rejected", prog_cnt - p0, 0);
        wr(16'h0555, 8'h90);
        wr(16'h0000, 8'h00);
        chk("R8 lock survives exit", sec_locked, 1);
        hw_reset();
        chk("R8 lock survives hardware reset", sec_locked, 1);
        @(negedge clk); vlow = 1'b1;
        repeat (3) @(negedge clk); vlow = 1'b0;
        @(negedge clk);
        chk("R8 lock survives low supply", sec_locked, 1);
        unlock();
        wr(16'h0555, 8'hA0);
        wr(16'h0300, 8'h7E);
        chk("R9 array program still starts", prog_cnt - p0, 1);
        chk("R9 array program region", last_psec, 0);
        power_on();
        chk("R8 power-on clears lock", sec_locked, 0);
    endtask

    initial begin
        fork
            begin
                t_reset_state();
                t_logic_inhibit();
                t_glitch();
                t_program();
                t_vlow();
                t_security();
                t_lock();
            end
            begin
                repeat (20000) @(negedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule